// File: doc/BRIEF.md
# Video Line Ping-Pong Packer

This block sits between a digitized 4:2:2 video source and a pair of narrow downstream FIFOs that a 32-bit reader drains side by side. Each pixel clock may carry one 16-bit sample: luma in bits 15:8, with Cb and Cr alternating sample by sample in bits 7:0. The sample is qualified by a valid strobe. A line-start marker tags the first sample of each active line, and a frame-start marker, given together with the line-start marker, tags the first line of a frame.

Samples are taken in pairs. The earlier sample of a pair goes to FIFO port A and the later one to FIFO port B, with both write strobes pulsing on the same cycle. The two FIFOs together therefore hold one 32-bit word per pair. A full line of 720 samples becomes 360 words.

The block tracks the sample position within the line and the line index within the frame. It drops anything outside the active window and pulses a frame interrupt once the final pair of the last line has been handled. A FIFO-full condition at write time drops the word and sets a sticky overflow flag, which a clear input resets.

Top module: `video_pingpong_packer`

## Requirements
- R1: When the second sample (odd index, counting from 0) of an accepted pair arrives, both `fifo_a_wr` and `fifo_b_wr` are high in the following cycle. `fifo_a_data` holds the earlier sample and `fifo_b_data` holds the later sample, bit for bit (luma in 15:8, chroma in 7:0).
- R2: The write strobes stay low on the first sample of a pair and last exactly one cycle.
- R3: A valid sample carrying the line-start marker is index 0 of a new line. A half pair left from an odd-length line is discarded, never paired.
- R4: Samples at index `SAMPLES_PER_LINE` or beyond within a line are ignored.
- R5: After reset, and after line `LINES_PER_FRAME-1` of a frame, every sample is ignored until a line-start marker arrives together with the frame-start marker. A line-start marker alone does not open a frame.
- R6: `frame_irq` is a one-cycle pulse in the cycle after the write strobes for the final pair of line `LINES_PER_FRAME-1`. It also fires if that word was dropped for overflow, and it never fires on other lines.
- R7: If `fifo_a_full` or `fifo_b_full` is high when a pair completes, neither strobe pulses and `overflow` goes high in the next cycle. It stays high until cleared.
- R8: `ovf_clear` resets `overflow` in the next cycle. A new overflow in the same cycle wins over the clear.
- R9: After reset, the strobes, `frame_irq` and `overflow` are all low.
- R10: Cycles with `smp_valid` low do not disturb pairing, and markers on such cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 16 | Sample: luma 15:8, chroma 7:0 |
| line_start | input | 1 | Marks the first sample of a line |
| frame_start | input | 1 | With line_start, marks line 0 of a frame |
| ovf_clear | input | 1 | Clears the overflow flag |
| fifo_a_full | input | 1 | FIFO A cannot accept a write |
| fifo_b_full | input | 1 | FIFO B cannot accept a write |
| fifo_a_wr | output | 1 | Write strobe, FIFO A |
| fifo_a_data | output | 16 | Earlier sample of the pair |
| fifo_b_wr | output | 1 | Write strobe, FIFO B |
| fifo_b_data | output | 16 | Later sample of the pair |
| frame_irq | output | 1 | One-cycle end-of-frame pulse |
| overflow | output | 1 | Sticky dropped-word flag |

## Verification
The bench runs a reduced geometry of 8 samples by 3 lines so that whole frames fit in a short run. It drives an odd-length line: a design that kept the stray half would place it in port A of the next line's first word. It also sends samples past the line end and after the last line, and lines that open with a bare line-start before any frame start; a design with a wrong window would pulse the strobes there. Further cases place idle cycles carrying markers inside a pair, hold a FIFO full on the final word of a frame (the interrupt must still fire), and assert the clear together with a new overflow.

// File: rtl/vpk_pkg.sv
package vpk_pkg;

    localparam int SAMPLE_W = 16;

    typedef struct packed {
        logic [7:0] luma;
        logic [7:0] chroma;
    } sample_t;

    typedef struct packed {
        sample_t early;
        sample_t late;
    } pair_word_t;

    typedef struct packed {
        logic accept;
        logic is_second;
        logic last_pair;
    } slot_t;

    function automatic sample_t to_sample(input logic [SAMPLE_W-1:0] raw);
        sample_t s;
        s.luma   = raw[15:8];
        s.chroma = raw[7:0];
        return s;
    endfunction

endpackage

// File: rtl/vpk_position.sv
module vpk_position
    import vpk_pkg::*;
#(
    parameter int SAMPLES_PER_LINE = 720,
    parameter int LINES_PER_FRAME  = 576
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  smp_valid,
    input  logic  line_start,
    input  logic  frame_start,
    output slot_t slot
);
    localparam int PIX_W  = $clog2(SAMPLES_PER_LINE + 1);
    localparam int LINE_W = $clog2(LINES_PER_FRAME + 1);
    localparam logic [PIX_W-1:0]  PIX_END  = PIX_W'(SAMPLES_PER_LINE);
    localparam logic [LINE_W-1:0] LINE_END = LINE_W'(LINES_PER_FRAME);

    logic [PIX_W-1:0]  pix_q, pix_idx;
    logic [LINE_W-1:0] line_q, line_eff;
    logic              in_line, in_frame;

    always_comb begin
        line_eff = line_q;
        if (smp_valid && line_start) begin
            if (frame_start)
                line_eff = '0;
            else if (line_q < LINE_END)
                line_eff = line_q + 1'b1;
        end
        pix_idx  = (smp_valid && line_start) ? '0 : pix_q;
        in_line  = pix_idx < PIX_END;
        in_frame = line_eff < LINE_END;

        slot.accept    = smp_valid && in_line && in_frame;
        slot.is_second = slot.accept && pix_idx[0];
        slot.last_pair = slot.is_second
                         && (pix_idx == PIX_END - 1'b1)
                         && (line_eff == LINE_END - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q  <= PIX_END;
            line_q <= LINE_END;
        end else begin
            line_q <= line_eff;
            if (smp_valid && in_line)
                pix_q <= pix_idx + 1'b1;
        end
    end

    assert_pix_bound_R4: assert property (@(posedge clk) disable iff (rst)
        pix_q <= PIX_END);

    assert_line_bound_R5: assert property (@(posedge clk) disable iff (rst)
        line_q <= LINE_END);

endmodule

// File: rtl/vpk_pair_packer.sv
module vpk_pair_packer
    import vpk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  slot_t               slot,
    input  logic [SAMPLE_W-1:0] smp_data,
    output pair_word_t          word
);
    sample_t held_q;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (slot.accept && !slot.is_second)
            held_q <= to_sample(smp_data);
    end

    always_comb begin
        word.early = held_q;
        word.late  = to_sample(smp_data);
    end

endmodule

// File: rtl/vpk_fifo_writer.sv
module vpk_fifo_writer
    import vpk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slot_t      slot,
    input  pair_word_t word,
    input  logic       full_a,
    input  logic       full_b,
    input  logic       clear,
    output logic       wr_a,
    output logic       wr_b,
    output sample_t    data_a,
    output sample_t    data_b,
    output logic       irq,
    output logic       ovf
);
    logic blocked, drop;
    logic last_q;

    assign blocked = full_a || full_b;
    assign drop    = slot.is_second && blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_a   <= 1'b0;
            wr_b   <= 1'b0;
            data_a <= '0;
            data_b <= '0;
            ovf    <= 1'b0;
            last_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            wr_a <= slot.is_second && !blocked;
            wr_b <= slot.is_second && !blocked;
            if (slot.is_second && !blocked) begin
                data_a <= word.early;
                data_b <= word.late;
            end
            ovf    <= drop || (ovf && !clear);
            last_q <= slot.last_pair;
            irq    <= last_q;
        end
    end

    assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        wr_a |=> !wr_a);

    assert_no_overflow_write_R7: assert property (@(posedge clk) disable iff (rst)
        (slot.is_second && (full_a || full_b)) |=> (!wr_a && !wr_b && ovf));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clear) |=> ovf);

    assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clear && !(slot.is_second && (full_a || full_b))) |=> !ovf);

    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

endmodule

// File: rtl/video_pingpong_packer.sv
module video_pingpong_packer
    import vpk_pkg::*;
#(
    parameter int SAMPLES_PER_LINE = 720,
    parameter int LINES_PER_FRAME  = 576
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_valid,
    input  logic [15:0] smp_data,
    input  logic        line_start,
    input  logic        frame_start,
    input  logic        ovf_clear,
    input  logic        fifo_a_full,
    input  logic        fifo_b_full,
    output logic        fifo_a_wr,
    output logic [15:0] fifo_a_data,
    output logic        fifo_b_wr,
    output logic [15:0] fifo_b_data,
    output logic        frame_irq,
    output logic        overflow
);
    slot_t      slot;
    pair_word_t word;
    sample_t    out_a, out_b;

    vpk_position #(
        .SAMPLES_PER_LINE(SAMPLES_PER_LINE),
        .LINES_PER_FRAME (LINES_PER_FRAME)
    ) u_position (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .line_start (line_start),
        .frame_start(frame_start),
        .slot       (slot)
    );

    vpk_pair_packer u_packer (
        .clk     (clk),
        .rst     (rst),
        .slot    (slot),
        .smp_data(smp_data),
        .word    (word)
    );

    vpk_fifo_writer u_writer (
        .clk   (clk),
        .rst   (rst),
        .slot  (slot),
        .word  (word),
        .full_a(fifo_a_full),
        .full_b(fifo_b_full),
        .clear (ovf_clear),
        .wr_a  (fifo_a_wr),
        .wr_b  (fifo_b_wr),
        .data_a(out_a),
        .data_b(out_b),
        .irq   (frame_irq),
        .ovf   (overflow)
    );

    assign fifo_a_data = out_a;
    assign fifo_b_data = out_b;

    initial begin
        assert_even_line_R1: assert (SAMPLES_PER_LINE % 2 == 0 && SAMPLES_PER_LINE > 0);
    end

    assert_strobes_paired_R1: assert property (@(posedge clk) disable iff (rst)
        fifo_a_wr == fifo_b_wr);

endmodule

// File: tb/video_pingpong_packer_tb.sv
module video_pingpong_packer_tb;
    localparam int SPL   = 8;
    localparam int LINES = 3;

    logic        clk = 0;
    logic        rst = 1;
    logic        smp_valid = 0;
    logic [15:0] smp_data = '0;
    logic        line_start = 0, frame_start = 0, ovf_clear = 0;
    logic        fifo_a_full = 0, fifo_b_full = 0;
    logic        fifo_a_wr, fifo_b_wr, frame_irq, overflow;
    logic [15:0] fifo_a_data, fifo_b_data;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    video_pingpong_packer #(.SAMPLES_PER_LINE(SPL), .LINES_PER_FRAME(LINES)) u_dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .line_start(line_start), .frame_start(frame_start), .ovf_clear(ovf_clear),
        .fifo_a_full(fifo_a_full), .fifo_b_full(fifo_b_full),
        .fifo_a_wr(fifo_a_wr), .fifo_a_data(fifo_a_data),
        .fifo_b_wr(fifo_b_wr), .fifo_b_data(fifo_b_data),
        .frame_irq(frame_irq), .overflow(overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] d, input logic ls, input logic fs, input logic v);
        @(negedge clk);
        smp_valid   = v;
        smp_data    = d;
        line_start  = ls;
        frame_start = fs;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(16'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic send_line(input logic [15:0] base, input logic fs, input int n,
                             input logic exp_wr, input string req);
        for (int i = 0; i < n; i++) begin
            drive(base + 16'(i), i == 0, fs && i == 0, 1'b1);
            if (i % 2 == 1 && i < SPL) begin
                chk(req, fifo_a_wr, exp_wr);
                chk(req, fifo_b_wr, exp_wr);
                if (exp_wr) begin
                    chk(req, fifo_a_data, base + 16'(i - 1));
                    chk(req, fifo_b_data, base + 16'(i));
                end
            end else begin
                chk("R2", fifo_a_wr, 0);
            end
        end
    endtask

    task automatic test_reset();
        chk("R9", fifo_a_wr, 0);
        chk("R9", fifo_b_wr, 0);
        chk("R9", frame_irq, 0);
        chk("R9", overflow, 0);
    endtask

    task automatic test_preframe();
        for (int i = 0; i < 4; i++) begin
            drive(16'hA000 + 16'(i), 1'b0, 1'b0, 1'b1);
            chk("R5", fifo_a_wr, 0);
        end
        send_line(16'hB000, 1'b0, 4, 1'b0, "R5");
    endtask

    task automatic test_frame();
        send_line(16'h1100, 1'b1, SPL, 1'b1, "R1");
        idle();
        chk("R2", fifo_a_wr, 0);
        chk("R6", frame_irq, 0);
        idle();
        chk("R6", frame_irq, 0);
        send_line(16'h2200, 1'b0, 5, 1'b1, "R3");
        drive(16'h3355, 1'b1, 1'b0, 1'b1);
        chk("R3", fifo_a_wr, 0);
        drive(16'h33AA, 1'b0, 1'b0, 1'b1);
        chk("R3", fifo_a_wr, 1);
        chk("R3", fifo_a_data, 16'h3355);
        chk("R3", fifo_b_data, 16'h33AA);
        for (int i = 2; i < SPL; i++) begin
            drive(16'h3300 + 16'(i), 1'b0, 1'b0, 1'b1);
            if (i % 2 == 1) chk("R1", fifo_b_data, 16'h3300 + 16'(i));
        end
        idle();
        chk("R6", frame_irq, 1);
        idle();
        chk("R6", frame_irq, 0);
        drive(16'h3399, 1'b0, 1'b0, 1'b1);
        drive(16'h339A, 1'b0, 1'b0, 1'b1);
        chk("R4", fifo_a_wr, 0);
    endtask

    task automatic test_after_frame();
        send_line(16'h4400, 1'b0, SPL, 1'b0, "R5");
        idle();
        chk("R5", frame_irq, 0);
    endtask

    task automatic test_gaps();
        drive(16'h5A01, 1'b1, 1'b1, 1'b1);
        idle();
        drive(16'h0000, 1'b1, 1'b1, 1'b0);
        chk("R10", fifo_a_wr, 0);
        drive(16'h5A02, 1'b0, 1'b0, 1'b1);
        chk("R10", fifo_a_wr, 1);
        chk("R10", fifo_a_data, 16'h5A01);
        chk("R10", fifo_b_data, 16'h5A02);
    endtask

    task automatic test_overflow();
        fifo_a_full = 1;
        drive(16'h6001, 1'b0, 1'b0, 1'b1);
        drive(16'h6002, 1'b0, 1'b0, 1'b1);
        chk("R7", fifo_a_wr, 0);
        chk("R7", fifo_b_wr, 0);
        chk("R7", overflow, 1);
        fifo_a_full = 0;
        drive(16'h6003, 1'b0, 1'b0, 1'b1);
        drive(16'h6004, 1'b0, 1'b0, 1'b1);
        chk("R7", fifo_a_wr, 1);
        chk("R7", fifo_a_data, 16'h6003);
        chk("R7", overflow, 1);
        ovf_clear = 1;
        idle();
        chk("R8", overflow, 0);
        ovf_clear = 0;
        drive(16'h6005, 1'b0, 1'b0, 1'b1);
        fifo_b_full = 1;
        ovf_clear   = 1;
        drive(16'h6006, 1'b0, 1'b0, 1'b1);
        chk("R8", overflow, 1);
        chk("R7", fifo_b_wr, 0);
        fifo_b_full = 0;
        ovf_clear   = 0;
    endtask

    task automatic test_overflow_last();
        send_line(16'h7100, 1'b0, SPL, 1'b1, "R1");
        fifo_b_full = 1;
        send_line(16'h7200, 1'b0, SPL, 1'b0, "R7");
        fifo_b_full = 0;
        idle();
        chk("R6", frame_irq, 1);
        idle();
        chk("R6", frame_irq, 0);
        ovf_clear = 1;
        idle();
        ovf_clear = 0;
        chk("R8", overflow, 0);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        test_reset();
        @(negedge clk);
        rst = 0;
        test_preframe();
        test_frame();
        test_after_frame();
        test_gaps();
        test_overflow();
        test_overflow_last();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule